// File: doc/BRIEF.md
# Character Device Port with Ready Flags and Gated Interrupt

This block connects one byte-wide input source (a keyboard-like producer) and one byte-wide output sink (a display-like consumer) to a simple processor bus. The processor reaches four registers through an address decoder: a receive data register, a transmit data register, a status register and a control register. Software can run the port in two ways. It can poll the status register until a ready flag is set, or it can set the interrupt enable bit and wait for the request line.

The receive side is a two-state machine. `RX_EMPTY` goes to `RX_FULL` when a byte arrives. `RX_FULL` goes back to `RX_EMPTY` when the processor reads the receive data register. A byte that arrives while the machine is in `RX_FULL` replaces the held byte and stays in `RX_FULL`. If that arrival is not paired with a read in the same cycle, it also raises a sticky overrun flag. The transmit side is also a two-state machine. `TX_IDLE` goes to `TX_SEND` when the processor writes the transmit data register, which latches the byte. `TX_SEND` goes back to `TX_IDLE` when the sink accepts the byte. The request line is the interrupt enable bit ANDed with the OR of the two ready flags.

An address has two fields. The upper 4 bits must equal the port's base value. The lower 2 bits select the register: 0 receive data, 1 transmit data, 2 status, 3 control. Read data is combinational while the read strobe is high, and register updates take effect on the clock edge that ends the access.

Top module: `chario_port`

## Requirements
- R1: After reset, status reads 0x02, control reads 0x00, `irq` is 0, `dsp_valid` is 0 and `kb_ready` is 1.
- R2: A byte taken while `kb_valid` is high is readable at offset 0, and status bit 0 (receive ready) reads 1 from the next cycle. `kb_ready` is always 1.
- R3: A read of offset 0 clears status bit 0 at the end of that access.
- R4: A write to offset 1 while status bit 1 (transmit ready) is 1 clears bit 1. From the next cycle `dsp_valid` is 1 and `dsp_data` shows the byte, and both hold until a cycle with `dsp_ready` high, after which bit 1 reads 1 again.
- R5: A write to offset 1 while status bit 1 is 0 is ignored, and the byte already presented on `dsp_data` is unchanged.
- R6: Control bit 2 is the interrupt enable bit, which is writable and reads back. All other control bits read 0.
- R7: `irq` is 1 exactly when the enable bit is 1 and status bit 0 or bit 1 is 1, and status bit 2 reads the same value as `irq`.
- R8: While the enable bit is 0, `irq` is 0 whatever the ready flags hold.
- R9: A byte that arrives while status bit 0 is 1 replaces the held byte and sets sticky status bit 3 (overrun). If a read of offset 0 happens in that same cycle, the read returns the old byte, bit 0 stays 1 and bit 3 is not set.
- R10: Writing 1 to status bit 3 clears it, and writing 0 leaves it unchanged. Writes to status bits 0 to 2 have no effect.
- R11: When the upper 4 address bits differ from the base value, a read returns 0 and a write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Base field (upper 4 bits) and register offset (lower 2 bits) |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high; 0 otherwise |
| irq | output | 1 | Interrupt request |
| kb_valid | input | 1 | Input source presents a byte |
| kb_data | input | 8 | Input byte |
| kb_ready | output | 1 | Port accepts input, always 1 |
| dsp_valid | output | 1 | Output byte presented to the sink |
| dsp_data | output | 8 | Output byte |
| dsp_ready | input | 1 | Sink accepts the presented byte |

## Verification
The hardest case to reach from the ports is a new byte arriving in the same cycle as the processor's read of the receive register while the receive side is already full. That cycle separates an overwrite from a true overrun. The stimulus first fills the receive register, then raises `kb_valid` together with the read strobe on a single edge. It then checks the byte returned, the overrun bit and the byte left for the next read. A second hard case is a transmit write while the sink is stalled. The bench keeps `dsp_ready` low for several cycles, writes a different byte during the stall, and checks that `dsp_data` does not move.

// File: rtl/chario_pkg.sv
package chario_pkg;

    typedef enum logic [1:0] {
        REG_RXD  = 2'd0,
        REG_TXD  = 2'd1,
        REG_STAT = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_FULL  = 1'b1
    } rx_state_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    localparam int STAT_RX_BIT  = 0;
    localparam int STAT_TX_BIT  = 1;
    localparam int STAT_IRQ_BIT = 2;
    localparam int STAT_OVR_BIT = 3;
    localparam int CTRL_IE_BIT  = 2;

endpackage

// File: rtl/chario_decode.sv
module chario_decode #(
    parameter int          BASE_W    = 4,
    parameter int          OFS_W     = 2,
    parameter logic [3:0]  BASE_ADDR = 4'hA,
    localparam int         ADDR_W    = BASE_W + OFS_W,
    localparam int         N_REG     = 1 << OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [N_REG-1:0]  sel_oh
);

    logic [BASE_W-1:0] base_f;
    logic [OFS_W-1:0]  ofs_f;

    assign base_f = addr[ADDR_W-1:OFS_W];
    assign ofs_f  = addr[OFS_W-1:0];
    assign hit    = (base_f == BASE_ADDR[BASE_W-1:0]);

    for (genvar g = 0; g < N_REG; g++) begin : g_sel
        assign sel_oh[g] = hit && (ofs_f == OFS_W'(g));
    end

endmodule

// File: rtl/chario_rx_fsm.sv
module chario_rx_fsm
    import chario_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_valid,
    input  logic [DATA_W-1:0] kb_data,
    input  logic              rd_take,
    input  logic              ovr_clr,
    output logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              ovr
);

    rx_state_e   state_q, state_d;
    logic        ovr_set;

    // next-state logic
    always_comb begin
        state_d = state_q;
        ovr_set = 1'b0;
        unique case (state_q)
            RX_EMPTY: begin
                if (kb_valid) state_d = RX_FULL;
            end
            RX_FULL: begin
                if (kb_valid) begin
                    state_d = RX_FULL;
                    ovr_set = !rd_take;
                end else if (rd_take) begin
                    state_d = RX_EMPTY;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
            rx_data <= '0;
            ovr     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (kb_valid) rx_data <= kb_data;
            if (ovr_set)      ovr <= 1'b1;
            else if (ovr_clr) ovr <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        rx_ready = (state_q == RX_FULL);
    end

endmodule

// File: rtl/chario_tx_fsm.sv
module chario_tx_fsm
    import chario_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dsp_ready,
    output logic              dsp_valid,
    output logic [DATA_W-1:0] dsp_data,
    output logic              tx_ready
);

    tx_state_e state_q, state_d;
    logic      load_en;

    // next-state logic
    always_comb begin
        state_d = state_q;
        load_en = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (wr_load) begin
                    state_d = TX_SEND;
                    load_en = 1'b1;
                end
            end
            TX_SEND: begin
                if (dsp_ready) state_d = TX_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= TX_IDLE;
            dsp_data <= '0;
        end else begin
            state_q <= state_d;
            if (load_en) dsp_data <= wdata;
        end
    end

    // outputs
    always_comb begin
        dsp_valid = (state_q == TX_SEND);
        tx_ready  = (state_q == TX_IDLE);
    end

endmodule

// File: rtl/chario_port.sv
module chario_port
    import chario_pkg::*;
#(
    parameter int         DATA_W    = 8,
    parameter int         BASE_W    = 4,
    parameter int         OFS_W     = 2,
    parameter logic [3:0] BASE_ADDR = 4'hA,
    localparam int        ADDR_W    = BASE_W + OFS_W,
    localparam int        N_REG     = 1 << OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              kb_valid,
    input  logic [DATA_W-1:0] kb_data,
    output logic              kb_ready,
    output logic              dsp_valid,
    output logic [DATA_W-1:0] dsp_data,
    input  logic              dsp_ready
);

    logic              hit;
    logic [N_REG-1:0]  sel_oh;
    logic              rx_ready, tx_ready, ovr_flag, ie_q;
    logic [DATA_W-1:0] rx_data;
    logic [DATA_W-1:0] stat_word, ctrl_word;
    logic              rd_take, wr_load, ovr_clr, ctrl_wr;
    logic              unused_wdata;

    chario_decode #(
        .BASE_W(BASE_W), .OFS_W(OFS_W), .BASE_ADDR(BASE_ADDR)
    ) dec_i (
        .addr(bus_addr), .hit(hit), .sel_oh(sel_oh)
    );

    assign rd_take = bus_rd && sel_oh[REG_RXD];
    assign wr_load = bus_wr && sel_oh[REG_TXD];
    assign ovr_clr = bus_wr && sel_oh[REG_STAT] && bus_wdata[STAT_OVR_BIT];
    assign ctrl_wr = bus_wr && sel_oh[REG_CTRL];
    assign unused_wdata = ^{bus_wdata[DATA_W-1:4], bus_wdata[1:0]};

    chario_rx_fsm #(.DATA_W(DATA_W)) rx_i (
        .clk(clk), .rst_n(rst_n),
        .kb_valid(kb_valid), .kb_data(kb_data),
        .rd_take(rd_take), .ovr_clr(ovr_clr),
        .rx_ready(rx_ready), .rx_data(rx_data), .ovr(ovr_flag)
    );

    chario_tx_fsm #(.DATA_W(DATA_W)) tx_i (
        .clk(clk), .rst_n(rst_n),
        .wr_load(wr_load), .wdata(bus_wdata),
        .dsp_ready(dsp_ready),
        .dsp_valid(dsp_valid), .dsp_data(dsp_data), .tx_ready(tx_ready)
    );

    // interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n)       ie_q <= 1'b0;
        else if (ctrl_wr) ie_q <= bus_wdata[CTRL_IE_BIT];
    end

    assign irq      = ie_q && (rx_ready || tx_ready);
    assign kb_ready = 1'b1;

    always_comb begin
        stat_word = '0;
        stat_word[STAT_RX_BIT]  = rx_ready;
        stat_word[STAT_TX_BIT]  = tx_ready;
        stat_word[STAT_IRQ_BIT] = irq;
        stat_word[STAT_OVR_BIT] = ovr_flag;
        ctrl_word = '0;
        ctrl_word[CTRL_IE_BIT]  = ie_q;
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (1'b1)
                sel_oh[REG_RXD]:  bus_rdata = rx_data;
                sel_oh[REG_TXD]:  bus_rdata = dsp_data;
                sel_oh[REG_STAT]: bus_rdata = stat_word;
                sel_oh[REG_CTRL]: bus_rdata = ctrl_word;
                default:          bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/chario_port_chk.sv
module chario_port_chk #(
    parameter int         DATA_W    = 8,
    parameter int         BASE_W    = 4,
    parameter int         OFS_W     = 2,
    parameter logic [3:0] BASE_ADDR = 4'hA,
    localparam int        ADDR_W    = BASE_W + OFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              kb_valid,
    input logic              dsp_valid,
    input logic              dsp_ready,
    input logic [DATA_W-1:0] dsp_data,
    input logic              rx_ready,
    input logic              tx_ready,
    input logic              ovr_flag
);

    logic             c_hit;
    logic [OFS_W-1:0] c_ofs;
    assign c_hit = (bus_addr[ADDR_W-1:OFS_W] == BASE_ADDR[BASE_W-1:0]);
    assign c_ofs = bus_addr[OFS_W-1:0];

    p_rx_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        kb_valid |=> rx_ready);

    p_rx_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && c_hit && c_ofs == 0 && !kb_valid) |=> !rx_ready);

    p_tx_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && c_hit && c_ofs == 1 && tx_ready) |=> (dsp_valid && !tx_ready));

    p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_data)));

    p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_ready || tx_ready));

    p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && c_hit && c_ofs == 3 && !bus_wdata[2]) |=> !irq);

    p_ovr_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !(bus_wr && c_hit && c_ofs == 2 && bus_wdata[3])) |=> ovr_flag);

    p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !c_hit) |-> (bus_rdata == '0));

endmodule

bind chario_port chario_port_chk #(
    .DATA_W(DATA_W), .BASE_W(BASE_W), .OFS_W(OFS_W), .BASE_ADDR(BASE_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .kb_valid(kb_valid), .dsp_valid(dsp_valid),
    .dsp_ready(dsp_ready), .dsp_data(dsp_data), .rx_ready(rx_ready),
    .tx_ready(tx_ready), .ovr_flag(ovr_flag)
);

// File: tb/chario_port_tb.sv
module chario_port_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam logic [3:0] BASE       = 4'hA;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_KB = 2'd2, OP_DSP = 2'd3;
    localparam int         NVEC = 24;

    // {op, offset, data (write data / expected read / byte), expected irq}
    localparam logic [12:0] VEC [NVEC] = '{
        {OP_RD,  2'd2, 8'h02, 1'b0},
        {OP_RD,  2'd3, 8'h00, 1'b0},
        {OP_KB,  2'd0, 8'h41, 1'b0},
        {OP_RD,  2'd2, 8'h03, 1'b0},
        {OP_RD,  2'd0, 8'h41, 1'b0},
        {OP_RD,  2'd2, 8'h02, 1'b0},
        {OP_WR,  2'd3, 8'hFF, 1'b0},
        {OP_RD,  2'd3, 8'h04, 1'b1},
        {OP_RD,  2'd2, 8'h06, 1'b1},
        {OP_WR,  2'd1, 8'h5A, 1'b1},
        {OP_RD,  2'd2, 8'h00, 1'b0},
        {OP_WR,  2'd1, 8'h33, 1'b0},
        {OP_DSP, 2'd0, 8'h5A, 1'b0},
        {OP_RD,  2'd2, 8'h06, 1'b1},
        {OP_KB,  2'd0, 8'h10, 1'b1},
        {OP_KB,  2'd0, 8'h20, 1'b1},
        {OP_RD,  2'd2, 8'h0F, 1'b1},
        {OP_RD,  2'd0, 8'h20, 1'b1},
        {OP_WR,  2'd2, 8'h07, 1'b1},
        {OP_RD,  2'd2, 8'h0E, 1'b1},
        {OP_WR,  2'd2, 8'h08, 1'b1},
        {OP_RD,  2'd2, 8'h06, 1'b1},
        {OP_WR,  2'd3, 8'h00, 1'b1},
        {OP_RD,  2'd2, 8'h02, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       kb_valid = 1'b0;
    logic [7:0] kb_data = '0;
    logic       kb_ready;
    logic       dsp_valid;
    logic [7:0] dsp_data;
    logic       dsp_ready = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chario_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .kb_valid(kb_valid), .kb_data(kb_data), .kb_ready(kb_ready),
        .dsp_valid(dsp_valid), .dsp_data(dsp_data), .dsp_ready(dsp_ready)
    );

    function automatic string vec_req(int i);
        case (i)
            0, 1:            return "R1";
            2, 3, 4:         return "R2";
            5:               return "R3";
            6, 7:            return "R6";
            8:               return "R7";
            9, 10, 13:       return "R4";
            11, 12:          return "R5";
            14, 15, 16, 17:  return "R9";
            18, 19, 20, 21:  return "R10";
            default:         return "R8";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        bus_rd = 1'b0; bus_wr = 1'b0; kb_valid = 1'b0; dsp_ready = 1'b0;
    endtask

    // one bus cycle: drive after negedge, sample before posedge, release after
    task automatic step(logic [1:0] op, logic [3:0] base, logic [1:0] ofs,
                        logic [7:0] data, output logic [7:0] rd_s);
        @(negedge clk);
        bus_addr = {base, ofs};
        case (op)
            OP_WR:  begin bus_wr = 1'b1; bus_wdata = data; end
            OP_RD:  bus_rd = 1'b1;
            OP_KB:  begin kb_valid = 1'b1; kb_data = data; end
            default: dsp_ready = 1'b1;
        endcase
        #1;
        rd_s = bus_rdata;
        @(posedge clk);
        #1;
        idle_all();
    endtask

    task automatic rd_chk(logic [3:0] base, logic [1:0] ofs, logic [7:0] exp, string req);
        logic [7:0] r;
        step(OP_RD, base, ofs, 8'h00, r);
        chk(req, {24'h0, r}, {24'h0, exp});
    endtask

    task automatic wr_do(logic [3:0] base, logic [1:0] ofs, logic [7:0] data);
        logic [7:0] r;
        step(OP_WR, base, ofs, data, r);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset values on the ports
        chk("R1", {31'h0, irq}, 32'h0);
        chk("R1", {31'h0, dsp_valid}, 32'h0);
        chk("R2", {31'h0, kb_ready}, 32'h1);

        // vector table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            logic [7:0] d;
            op = VEC[i][12:11];
            d  = VEC[i][8:1];
            @(negedge clk);
            bus_addr = {BASE, VEC[i][10:9]};
            case (op)
                OP_WR:  begin bus_wr = 1'b1; bus_wdata = d; end
                OP_RD:  bus_rd = 1'b1;
                OP_KB:  begin kb_valid = 1'b1; kb_data = d; end
                default: dsp_ready = 1'b1;
            endcase
            #1;
            chk(vec_req(i), {31'h0, irq}, {31'h0, VEC[i][0]});
            if (op == OP_RD) chk(vec_req(i), {24'h0, bus_rdata}, {24'h0, d});
            if (op == OP_DSP) begin
                chk(vec_req(i), {31'h0, dsp_valid}, 32'h1);
                chk(vec_req(i), {24'h0, dsp_data}, {24'h0, d});
            end
            @(posedge clk);
            #1;
            idle_all();
        end

        // R9: arrival in the same cycle as the read of a full register
        step(OP_KB, BASE, 2'd0, 8'h11, r);
        @(negedge clk);
        bus_addr = {BASE, 2'd0};
        bus_rd = 1'b1; kb_valid = 1'b1; kb_data = 8'h22;
        #1;
        chk("R9", {24'h0, bus_rdata}, 32'h11);
        @(posedge clk);
        #1;
        idle_all();
        rd_chk(BASE, 2'd2, 8'h03, "R9");
        rd_chk(BASE, 2'd0, 8'h22, "R9");

        // R4 / R5: stalled sink keeps the byte steady
        wr_do(BASE, 2'd1, 8'h77);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            chk("R4", {31'h0, dsp_valid}, 32'h1);
            chk("R4", {24'h0, dsp_data}, 32'h77);
        end
        wr_do(BASE, 2'd1, 8'h99);
        @(negedge clk);
        #1;
        chk("R5", {24'h0, dsp_data}, 32'h77);
        step(OP_DSP, BASE, 2'd0, 8'h00, r);
        rd_chk(BASE, 2'd2, 8'h02, "R4");

        // R11: foreign base value
        wr_do(4'h5, 2'd3, 8'hFF);
        rd_chk(BASE, 2'd3, 8'h00, "R11");
        rd_chk(4'h5, 2'd2, 8'h00, "R11");
        chk("R11", {31'h0, irq}, 32'h0);

        // R7: receive flag alone raises the request, R8 gating with enable off
        wr_do(BASE, 2'd1, 8'h01);
        step(OP_KB, BASE, 2'd0, 8'h44, r);
        #1;
        chk("R8", {31'h0, irq}, 32'h0);
        wr_do(BASE, 2'd3, 8'h04);
        #1;
        chk("R7", {31'h0, irq}, 32'h1);
        rd_chk(BASE, 2'd0, 8'h44, "R7");
        #1;
        chk("R7", {31'h0, irq}, 32'h0);

        // R1: reset in the middle of activity
        step(OP_KB, BASE, 2'd0, 8'h55, r);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_chk(BASE, 2'd2, 8'h02, "R1");
        rd_chk(BASE, 2'd3, 8'h00, "R1");
        #1;
        chk("R1", {31'h0, dsp_valid}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule